// File: doc/BRIEF.md
# Two-Channel DMA Control and Status Register Bank

This block holds the software-visible registers of a two-channel descriptor-chained DMA engine. Channel 0 feeds memory into an outgoing stream and channel 1 drains an incoming stream into memory. Each channel has a control word, a status word, a current-descriptor pointer, a tail-descriptor pointer and a few plain scratch words. A single 32-bit register port reads and writes them. The block splits the address into a channel and a word offset, handles the per-channel soft reset, and tracks the run, halted and idle state.

The descriptor engines act on the bank through side inputs. They can set the idle or halted bit, raise any of the three interrupt flags, or load a new current-descriptor pointer. Their completion counter and delay timer are not part of this block; their 8-bit values only appear in the status readback. When software writes the channel-0 tail pointer, the block sends a one-cycle start request to the transmit engine. Each channel drives an interrupt line built from its enabled flags.

Top module: `dma_csr_bank`

## Requirements
- R1: The channel is bit 0 of (address / 48) and the word is (address mod 48) / 4. Word 0 is control, word 1 is status, word 2 is the current pointer and word 4 is the tail pointer. Words 3 and 5 to 11 are plain read/write storage. A read returns its data on `csr_rdata` with `csr_rvalid` high in the cycle after the read is accepted.
- R2: After hard reset, each channel's control reads 0x00010000 and its stored status is 0x0001 (halted). Run, idle, interrupt and `tx_start` are low.
- R3: A control write with bit 2 set is a soft reset of that channel. Control becomes 0x00010006 (threshold 1, tail mode, reset bit held) and status becomes 0x0001. Run is cleared, and the idle bit and the interrupt flags are cleared.
- R4: Any other control write stores the written value with bit 1 forced to 1 and the held bit 2 ORed in. If bit 0 is set and no reset bit is held, it also clears halted (status bit 0) and idle (status bit 1). `ch_run` follows control bit 0.
- R5: A control read returns the control value with bit 2 cleared, and it clears the held reset bit.
- R6: A status write clears status bits 14:12 where the written value has ones and leaves them where it has zeros. The other bits of [15:0] take the written value.
- R7: A status read returns {delay count[7:0], completion count[7:0], stored status[15:0]}.
- R8: A tail-pointer write stores the value and clears idle. On channel 0 only, `tx_start` is high for the one cycle after the write.
- R9: `ch_irq` of a channel is the OR of bits 14:12 of (status AND control).
- R10: In the same cycle, engine events set status bit 0 (halt), bit 1 (idle) and bits 14:12 (flags) after any software clear, so an event is never lost. An engine pointer load takes priority over a software write to the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | ADDR_W | Byte address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data |
| csr_rvalid | output | 1 | Read data valid |
| cmpl_cnt | input | 16 | Completion counts, 8 bits per channel |
| dly_cnt | input | 16 | Delay timer counts, 8 bits per channel |
| eng_idle_set | input | 2 | Engine sets idle, per channel |
| eng_halt_set | input | 2 | Engine sets halted, per channel |
| eng_flag_set | input | 6 | Engine raises flags 14:12, 3 per channel |
| eng_cur_we | input | 2 | Engine loads current pointer |
| eng_cur_val | input | 64 | Engine pointer values, 32 per channel |
| ch_run | output | 2 | Run bit per channel |
| ch_idle | output | 2 | Idle bit per channel |
| ch_halted | output | 2 | Halted bit per channel |
| ch_irq | output | 2 | Interrupt per channel |
| tx_start | output | 1 | Start request to the transmit engine |

## Verification
A software status write or tail write can land in the same cycle as an engine event on the same channel. Two cases matter: a write-one-to-clear of a flag while the engine raises that same flag, and a tail-pointer write while the engine reports idle. The bench drives each pair in one cycle and checks that the engine's bit stays set on the next cycle. It also drives a software current-pointer write against an engine load and expects the engine's value on readback.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
  localparam int NCH       = 2;
  localparam int DW        = 32;
  localparam int CW        = 8;
  localparam int FLAG_W    = 3;
  localparam int FLAG_LO   = 12;
  localparam int WIN_BYTES = 48;
  localparam int IDX_W     = 4;
  localparam int SPARE_N   = 8;

  localparam logic [IDX_W-1:0] IDX_CTRL = 4'd0;
  localparam logic [IDX_W-1:0] IDX_STAT = 4'd1;
  localparam logic [IDX_W-1:0] IDX_CUR  = 4'd2;
  localparam logic [IDX_W-1:0] IDX_TAIL = 4'd4;

  localparam logic [DW-1:0] CTRL_HARD_RST = 32'h0001_0000;
  localparam logic [DW-1:0] CTRL_SOFT_RST = 32'h0001_0006;
  localparam logic [15:0]   STAT_RST      = 16'h0001;

  // control value as stored after a write: tail mode forced, held reset kept
  function automatic logic [DW-1:0] ctrl_merge(input logic [DW-1:0] wv, input logic held);
    logic [DW-1:0] r;
    r    = wv;
    r[1] = 1'b1;
    r[2] = wv[2] | held;
    return r;
  endfunction

  // write-one-to-clear on the flag field, plain store elsewhere
  function automatic logic [15:0] stat_w1c(input logic [15:0] old, input logic [15:0] wv);
    logic [15:0] r;
    r = wv;
    r[FLAG_LO+:FLAG_W] = old[FLAG_LO+:FLAG_W] & ~wv[FLAG_LO+:FLAG_W];
    return r;
  endfunction

  function automatic logic [DW-1:0] stat_view(input logic [15:0] st,
                                               input logic [CW-1:0] cmpl,
                                               input logic [CW-1:0] dly);
    return {dly, cmpl, st};
  endfunction

  function automatic logic irq_of(input logic [DW-1:0] ctl, input logic [15:0] st);
    return |(ctl[FLAG_LO+:FLAG_W] & st[FLAG_LO+:FLAG_W]);
  endfunction
endpackage

// File: rtl/dcsr_decode.sv
module dcsr_decode import dcsr_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ch_sel,
  output logic [IDX_W-1:0]  word_idx
);
  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_BYTES);

  always_comb begin
    ch_sel   = 1'(addr / WIN);
    word_idx = IDX_W'((addr % WIN) >> 2);
  end
endmodule

// File: rtl/dcsr_chan.sv
module dcsr_chan import dcsr_pkg::*; #(
  parameter bit IS_TX = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DW-1:0]     wdata,
  input  logic [CW-1:0]     cmpl_cnt,
  input  logic [CW-1:0]     dly_cnt,
  input  logic              ev_idle,
  input  logic              ev_halt,
  input  logic [FLAG_W-1:0] ev_flags,
  input  logic              ev_cur_we,
  input  logic [DW-1:0]     ev_cur,
  output logic [DW-1:0]     rd_word,
  output logic              run,
  output logic              idle,
  output logic              halted,
  output logic              irq,
  output logic              kick
);
  logic [DW-1:0] ctrl_q, ctrl_d, cur_q, cur_d, tail_q;
  logic [15:0]   stat_q, stat_sw, stat_d;
  logic [DW-1:0] spare_q [SPARE_N];

  logic hit_ctrl_wr, srst_req, resetting, start_req;
  logic stat_wr, cur_wr, tail_wr, ctrl_rd, spare_hit, spare_wr;
  logic [2:0] sp_idx;

  assign resetting   = ctrl_q[2];
  assign hit_ctrl_wr = wr_en && (idx == IDX_CTRL);
  assign srst_req    = hit_ctrl_wr && wdata[2];
  assign start_req   = hit_ctrl_wr && !wdata[2] && wdata[0] && !resetting;
  assign ctrl_rd     = rd_en && (idx == IDX_CTRL);
  assign stat_wr     = wr_en && (idx == IDX_STAT);
  assign cur_wr      = wr_en && (idx == IDX_CUR);
  assign tail_wr     = wr_en && (idx == IDX_TAIL);
  assign spare_hit   = (idx == 4'd3) || ((idx >= 4'd5) && (idx <= 4'd11));
  assign spare_wr    = wr_en && spare_hit;
  assign sp_idx      = (idx == 4'd3) ? 3'd0 : 3'(idx - 4'd4);

  generate
    if (IS_TX) begin : g_tx
      assign kick = tail_wr;
    end else begin : g_rx
      assign kick = 1'b0;
    end
  endgenerate

  always_comb begin
    ctrl_d  = ctrl_q;
    stat_sw = stat_q;
    if (srst_req) begin
      ctrl_d  = CTRL_SOFT_RST;
      stat_sw = STAT_RST;
    end else if (hit_ctrl_wr) begin
      ctrl_d = ctrl_merge(wdata, resetting);
      if (start_req) stat_sw[1:0] = 2'b00;
    end
    if (ctrl_rd) ctrl_d[2] = 1'b0;
    if (stat_wr) stat_sw = stat_w1c(stat_q, wdata[15:0]);
    if (tail_wr) stat_sw[1] = 1'b0;
    // engine events land after software clears
    stat_d = stat_sw | {1'b0, ev_flags, 10'b0, ev_idle, ev_halt};
    cur_d  = ev_cur_we ? ev_cur : (cur_wr ? wdata : cur_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_HARD_RST;
      stat_q <= STAT_RST;
      cur_q  <= '0;
      tail_q <= '0;
      for (int i = 0; i < SPARE_N; i++) spare_q[i] <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      cur_q  <= cur_d;
      if (tail_wr)  tail_q <= wdata;
      if (spare_wr) spare_q[sp_idx] <= wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    case (idx)
      IDX_CTRL: rd_word = ctrl_q & ~32'h4;
      IDX_STAT: rd_word = stat_view(stat_q, cmpl_cnt, dly_cnt);
      IDX_CUR:  rd_word = cur_q;
      IDX_TAIL: rd_word = tail_q;
      default:  if (spare_hit) rd_word = spare_q[sp_idx];
    endcase
  end

  assign run    = ctrl_q[0];
  assign idle   = stat_q[1];
  assign halted = stat_q[0];
  assign irq    = irq_of(ctrl_q, stat_q);

  // R3
  srst_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_req && !ev_idle) |=> (halted && !run && !idle));
  // R4
  run_clears_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !ev_halt && !ev_idle) |=> (run && !halted && !idle));
  // R5
  rd_drops_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !wr_en) |=> !resetting);
  // R6
  w1c_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wdata[FLAG_LO] && !ev_flags[0]) |=> !stat_q[FLAG_LO]);
  // R8
  tail_unidle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_wr && !ev_idle) |=> !idle);
  // R10
  ev_halt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_halt |=> halted);
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank import dcsr_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csr_wr,
  input  logic                 csr_rd,
  input  logic [ADDR_W-1:0]    csr_addr,
  input  logic [DW-1:0]        csr_wdata,
  output logic [DW-1:0]        csr_rdata,
  output logic                 csr_rvalid,
  input  logic [NCH*CW-1:0]    cmpl_cnt,
  input  logic [NCH*CW-1:0]    dly_cnt,
  input  logic [NCH-1:0]       eng_idle_set,
  input  logic [NCH-1:0]       eng_halt_set,
  input  logic [NCH*FLAG_W-1:0] eng_flag_set,
  input  logic [NCH-1:0]       eng_cur_we,
  input  logic [NCH*DW-1:0]    eng_cur_val,
  output logic [NCH-1:0]       ch_run,
  output logic [NCH-1:0]       ch_idle,
  output logic [NCH-1:0]       ch_halted,
  output logic [NCH-1:0]       ch_irq,
  output logic                 tx_start
);
  logic             ch_sel;
  logic [IDX_W-1:0] word_idx;
  logic [DW-1:0]    rd_words [NCH];
  logic [NCH-1:0]   kick;
  logic             tail_wr_ch0;

  dcsr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(csr_addr), .ch_sel(ch_sel), .word_idx(word_idx)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      dcsr_chan #(.IS_TX(c == 0)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (csr_wr && (ch_sel == 1'(c))),
        .rd_en    (csr_rd && (ch_sel == 1'(c))),
        .idx      (word_idx),
        .wdata    (csr_wdata),
        .cmpl_cnt (cmpl_cnt[c*CW +: CW]),
        .dly_cnt  (dly_cnt[c*CW +: CW]),
        .ev_idle  (eng_idle_set[c]),
        .ev_halt  (eng_halt_set[c]),
        .ev_flags (eng_flag_set[c*FLAG_W +: FLAG_W]),
        .ev_cur_we(eng_cur_we[c]),
        .ev_cur   (eng_cur_val[c*DW +: DW]),
        .rd_word  (rd_words[c]),
        .run      (ch_run[c]),
        .idle     (ch_idle[c]),
        .halted   (ch_halted[c]),
        .irq      (ch_irq[c]),
        .kick     (kick[c])
      );
    end
  endgenerate

  assign tail_wr_ch0 = csr_wr && !ch_sel && (word_idx == IDX_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_rdata  <= '0;
      csr_rvalid <= 1'b0;
      tx_start   <= 1'b0;
    end else begin
      csr_rvalid <= csr_rd;
      if (csr_rd) csr_rdata <= rd_words[ch_sel];
      tx_start <= |kick;
    end
  end

  // R8
  tx_from_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(tail_wr_ch0));
  // R1
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rvalid |-> $past(csr_rd));
endmodule

// File: tb/dma_csr_bank_test.sv
module dma_csr_bank_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        csr_wr = 0, csr_rd = 0;
  logic [7:0]  csr_addr = 0;
  logic [31:0] csr_wdata = 0;
  logic [31:0] csr_rdata;
  logic        csr_rvalid;
  logic [15:0] cmpl_cnt = 16'h115A;
  logic [15:0] dly_cnt  = 16'h223C;
  logic [1:0]  eng_idle_set = 0, eng_halt_set = 0, eng_cur_we = 0;
  logic [5:0]  eng_flag_set = 0;
  logic [63:0] eng_cur_val = 0;
  logic [1:0]  ch_run, ch_idle, ch_halted, ch_irq;
  logic        tx_start;

  dma_csr_bank uut (.*);

  int checks = 0, errors = 0;
  logic [31:0] m_ctl [2];
  logic [15:0] m_st  [2];
  logic [31:0] m_cur [2];
  logic [31:0] m_tail[2];
  logic [31:0] m_sp  [2][12];
  logic        exp_rv, exp_tx;
  logic [31:0] exp_rd;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock: advance the reference model, then compare every output
  task automatic tick(string tag);
    int a, c, k;
    a = csr_addr; c = (a / 48) % 2; k = (a % 48) / 4;
    exp_tx = 1'b0;
    exp_rv = csr_rd;
    if (csr_wr) begin
      case (k)
        0: if (csr_wdata[2]) begin
             m_ctl[c] = 32'h0001_0006; m_st[c] = 16'h0001;
           end else begin
             if (csr_wdata[0] && !m_ctl[c][2]) m_st[c] = m_st[c] & 16'hFFFC;
             m_ctl[c] = csr_wdata | 32'h2 | (m_ctl[c] & 32'h4);
           end
        1: m_st[c] = (csr_wdata[15:0] & 16'h8FFF) | (m_st[c] & 16'h7000 & ~csr_wdata[15:0]);
        2: m_cur[c] = csr_wdata;
        4: begin
             m_tail[c] = csr_wdata; m_st[c][1] = 1'b0;
             if (c == 0) exp_tx = 1'b1;
           end
        default: m_sp[c][k] = csr_wdata;
      endcase
    end
    if (csr_rd) begin
      case (k)
        0: begin exp_rd = m_ctl[c] & ~32'h4; m_ctl[c][2] = 1'b0; end
        1: exp_rd = {dly_cnt[c*8 +: 8], cmpl_cnt[c*8 +: 8], m_st[c]};
        2: exp_rd = m_cur[c];
        4: exp_rd = m_tail[c];
        default: exp_rd = m_sp[c][k];
      endcase
    end
    for (int ch = 0; ch < 2; ch++) begin
      if (eng_halt_set[ch]) m_st[ch][0] = 1'b1;
      if (eng_idle_set[ch]) m_st[ch][1] = 1'b1;
      m_st[ch][14:12] = m_st[ch][14:12] | eng_flag_set[ch*3 +: 3];
      if (eng_cur_we[ch]) m_cur[ch] = eng_cur_val[ch*32 +: 32];
    end
    @(posedge clk); #2;
    for (int ch = 0; ch < 2; ch++) begin
      chk(tag, "run",    32'(ch_run[ch]),    32'(m_ctl[ch][0]));
      chk(tag, "idle",   32'(ch_idle[ch]),   32'(m_st[ch][1]));
      chk(tag, "halted", 32'(ch_halted[ch]), 32'(m_st[ch][0]));
      chk(tag, "irq",    32'(ch_irq[ch]),    32'(|(m_st[ch][14:12] & m_ctl[ch][14:12])));
    end
    chk(tag, "tx_start", 32'(tx_start), 32'(exp_tx));
    chk(tag, "rvalid",   32'(csr_rvalid), 32'(exp_rv));
    if (exp_rv) chk(tag, "rdata", csr_rdata, exp_rd);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
    csr_wr = 1; csr_addr = a; csr_wdata = d; tick(tag); csr_wr = 0;
  endtask
  task automatic rd(logic [7:0] a, string tag);
    csr_rd = 1; csr_addr = a; tick(tag); csr_rd = 0;
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: all requirements, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_ctl[c] = 32'h0001_0000; m_st[c] = 16'h0001; m_cur[c] = 0; m_tail[c] = 0;
      for (int k = 0; k < 12; k++) m_sp[c][k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    tick("R2");
    rd(8'h00, "R2"); rd(8'h04, "R2"); rd(8'h30, "R2"); rd(8'h34, "R7");
    // R4 run start on channel 0 with all flag enables
    wr(8'h00, 32'h0000_7001, "R4");
    rd(8'h00, "R4");
    // R9 / R10 engine flags raise irq
    eng_flag_set = 6'b000_001; tick("R9"); eng_flag_set = 0;
    rd(8'h04, "R7");
    // R6 write-one-to-clear
    wr(8'h04, 32'h0000_1000, "R6");
    eng_flag_set = 6'b000_110; tick("R9"); eng_flag_set = 0;
    wr(8'h04, 32'h0000_2A50, "R6");   // clears bit 13, keeps 14, stores others
    rd(8'h04, "R6");
    // R10 same-cycle clear vs engine raise
    eng_flag_set = 6'b000_001; wr(8'h04, 32'h0000_5000, "R10"); eng_flag_set = 0;
    rd(8'h04, "R10");
    // R8 tail writes
    eng_idle_set = 2'b01; tick("R10"); eng_idle_set = 0;
    wr(8'h10, 32'h0000_1240, "R8");
    rd(8'h10, "R8");
    wr(8'h40, 32'h0000_8880, "R8");   // channel 1: no start
    rd(8'h40, "R8");
    // R10 tail write against engine idle in one cycle
    eng_idle_set = 2'b01; wr(8'h10, 32'h0000_1280, "R10"); eng_idle_set = 0;
    eng_halt_set = 2'b10; tick("R10"); eng_halt_set = 0;
    // R3 soft reset channel 1, reset bit held
    wr(8'h30, 32'h0000_7001, "R4");
    wr(8'h30, 32'h0000_0004, "R3");
    wr(8'h30, 32'h0000_0001, "R4");   // held reset: halted stays
    rd(8'h30, "R5");
    rd(8'h30, "R5");
    wr(8'h30, 32'h0000_0001, "R4");   // now runs
    // R3 on channel 0 clears flags and idle
    wr(8'h00, 32'h0000_7005, "R3");
    rd(8'h04, "R3");
    rd(8'h00, "R5");
    // R1 decode: spare words, aliasing, pointers
    wr(8'h0C, 32'hA5A5_0001, "R1");
    wr(8'h2C, 32'h5A5A_0002, "R1");
    wr(8'h3C, 32'h1234_0003, "R1");
    wr(8'h08, 32'h0000_4000, "R1");
    rd(8'h0C, "R1"); rd(8'h2C, "R1"); rd(8'h3C, "R1");
    rd(8'h6C, "R1");                  // aliases channel 0 word 3
    rd(8'h08, "R1");
    // R10 engine pointer load beats software write
    eng_cur_we = 2'b10; eng_cur_val = 64'hCAFE_0100_0000_0000;
    wr(8'h38, 32'h0000_0777, "R10");
    eng_cur_we = 0;
    rd(8'h38, "R10");
    repeat (3) tick("R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule